// File: doc/BRIEF.md
# Timer Compare Output Unit

A 16-bit up-counter with three compare channels (A, B, C). The counter moves forward by one on every cycle where the prescaled count-enable input is high. It runs in one of two modes. In free-running mode it wraps from its maximum value to zero, and that wrap raises an overflow flag. In clear-on-match mode it goes back to zero after it reaches the channel A compare value.

Each channel keeps a compare output bit. On a compare match, a 2-bit action code changes that bit: it can hold, toggle, clear or set it. When a channel's code is nonzero, its compare output takes the place of the ordinary port value on the pin. A direction bit independently enables the pin driver.

Software reaches every register through a simple single-cycle register bus. Writes take effect at the clock edge. Reads are combinational from the address. The overflow flag drives the interrupt request. The flag is cleared by an interrupt acknowledge pulse or by writing a one to it. The block has no data stream; all of its pins are plain control and status signals, so it has no valid/ready handshake and no back-pressure.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, all three compare outputs are 0, `pin_oe` is 0 and `irq` is 0.
- R2: The register addresses are as follows:
  - 0: control. Bits [7:6] hold the channel A action code, [5:4] channel B, [3:2] channel C, and [1:0] the mode.
  - 1: count.
  - 2, 3, 4: the compare values of A, B and C.
  - 5: flag, overflow at bit 0.
  - 6: direction. Bit 0 is A, bit 1 is B, bit 2 is C.
  
  Every register reads back what was written, except the flag.
- R3: In free-running mode (mode 00, and also the reserved modes 10 and 11), each enabled cycle adds one to the count. The count wraps from all-ones to 0.
- R4: On a compare match, action code 1 toggles the channel output, 2 drives it to 0, 3 drives it to 1, and 0 leaves it unchanged. The output also holds its value while the code is 0.
- R5: `pin_out[i]` carries the compare output of channel i when that channel's code is nonzero; otherwise it carries `port_val[i]`. `pin_oe[i]` equals direction bit i.
- R6: A match occurs only on a cycle where the count advances and the current count equals the compare value. Writing a compare value or the count, with no advance, causes no match.
- R7: A bus write to the count in the same cycle as `cnt_tick` takes priority. The count takes the written value and gives no advance, no match and no overflow.
- R8: In clear-on-match mode (mode 01), an advance while the count equals the channel A compare value loads 0, and no overflow is flagged.
- R9: In free-running mode, the advance from all-ones sets the overflow flag. `irq` equals the flag.
- R10: The flag clears on an `irq_ack` pulse, or on a bus write to address 5 with bit 0 high. Writing 0 to it has no effect.
- R11: When a set and a clear of the flag happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| cnt_tick | input | 1 | Prescaled count enable |
| irq_ack | input | 1 | Overflow interrupt acknowledge pulse |
| port_val | input | 3 | Ordinary port values for pins A, B, C |
| pin_out | output | 3 | Pin values for A, B, C |
| pin_oe | output | 3 | Pin driver enables for A, B, C |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with the default `CNT_W` of 16, the width the control layout and the overflow flag are defined for. Writes to the count preload it near all-ones, so the wrap, the overflow flag and the set-beats-clear race each occur within a few cycles instead of 65536. Loading counts and compare values directly also makes every match of each action code, and the clear-on-match restart, land on a known cycle.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int NUM_CH = 3;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } match_act_e;

  typedef enum logic [1:0] {
    WAVE_FREE = 2'd0,
    WAVE_CTC  = 2'd1,
    WAVE_RSV2 = 2'd2,
    WAVE_RSV3 = 2'd3
  } wave_e;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_CMP_A = 3'd2;
  localparam logic [2:0] ADDR_FLAG  = 3'd5;
  localparam logic [2:0] ADDR_DIR   = 3'd6;
endpackage

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [2:0]          bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [NUM_CH-1:0]   dir_q,
  output logic                wr_count,
  output logic                wr_flag,
  output logic [NUM_CH-1:0]   wr_cmp
);
  logic bus_wr;
  assign bus_wr   = bus_sel & bus_we;
  assign wr_count = bus_wr && (bus_addr == ADDR_COUNT);
  assign wr_flag  = bus_wr && (bus_addr == ADDR_FLAG);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp_dec
    localparam logic [2:0] CH_ADDR = 3'(ADDR_CMP_A + i);
    assign wr_cmp[i] = bus_wr && (bus_addr == CH_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dir_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_addr == ADDR_DIR)  dir_q  <= bus_wdata[NUM_CH-1:0];
    end
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTRL) |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ctc,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count_q,
  output logic             step,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_top;
  assign step   = tick & ~wr_en;
  assign at_top = ctc && (count_q == top);
  assign wrap   = step & ~ctc & (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (wr_en)   count_q <= wr_data;
    else if (tick) begin
      if (at_top)     count_q <= '0;
      else            count_q <= count_q + 1'b1;
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(ctc && count_q == top)) |=> count_q == $past(count_q) + 1'b1);
  assert_ctc_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctc && count_q == top) |=> count_q == '0);
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_q == $past(wr_data));
endmodule

// File: rtl/tcu_channel.sv
module tcu_channel
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             step,
  input  match_act_e       act,
  output logic [CNT_W-1:0] cmp_q,
  output logic             oc_q
);
  logic hit;
  assign hit = step && (count == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_wr) cmp_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else if (hit) begin
      case (act)
        ACT_TOGGLE: oc_q <= ~oc_q;
        ACT_LOW:    oc_q <= 1'b0;
        ACT_HIGH:   oc_q <= 1'b1;
        default:    oc_q <= oc_q;
      endcase
    end
  end

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_TOGGLE) |=> oc_q != $past(oc_q));
  assert_drive_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_LOW) |=> !oc_q);
  assert_drive_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_HIGH) |=> oc_q);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || act == ACT_NONE) |=> $stable(oc_q));
endmodule

// File: rtl/tcu_ovf_flag.sv
module tcu_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic wr_flag,
  input  logic wr_bit,
  output logic flag_q
);
  logic clr;
  assign clr = ack | (wr_flag & wr_bit);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(flag_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cnt_tick,
  input  logic             irq_ack,
  input  logic [2:0]       port_val,
  output logic [2:0]       pin_out,
  output logic [2:0]       pin_oe,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] dir_q;
  logic              wr_count, wr_flag;
  logic [NUM_CH-1:0] wr_cmp;
  logic [CNT_W-1:0]  count_q;
  logic              step, wrap, flag_q, ctc;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [NUM_CH-1:0] oc_q;
  wave_e             wave;

  tcu_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q),
    .dir_q(dir_q), .wr_count(wr_count), .wr_flag(wr_flag), .wr_cmp(wr_cmp)
  );

  assign wave = wave_e'(ctrl_q[1:0]);
  assign ctc  = (wave == WAVE_CTC);

  tcu_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .wr_en(wr_count),
    .wr_data(bus_wdata), .ctc(ctc), .top(cmp_q[0]),
    .count_q(count_q), .step(step), .wrap(wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    match_act_e act;
    assign act = match_act_e'(ctrl_q[CTRL_W-1-2*i -: 2]);

    tcu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .cmp_wr(wr_cmp[i]), .wdata(bus_wdata),
      .count(count_q), .step(step), .act(act),
      .cmp_q(cmp_q[i]), .oc_q(oc_q[i])
    );

    assign pin_out[i] = (act != ACT_NONE) ? oc_q[i] : port_val[i];
    assign pin_oe[i]  = dir_q[i];
  end

  tcu_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wrap), .ack(irq_ack),
    .wr_flag(wr_flag), .wr_bit(bus_wdata[0]), .flag_q(flag_q)
  );

  assign irq = flag_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_COUNT: bus_rdata = count_q;
      3'd2:       bus_rdata = cmp_q[0];
      3'd3:       bus_rdata = cmp_q[1];
      3'd4:       bus_rdata = cmp_q[2];
      ADDR_FLAG:  bus_rdata[0] = flag_q;
      ADDR_DIR:   bus_rdata[NUM_CH-1:0] = dir_q;
      default:    bus_rdata = '0;
    endcase
  end

  assert_no_ovf_in_ctc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && !flag_q && !(wr_flag && !bus_wdata[0])) |=> !flag_q);
endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]       bus_addr = '0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic             cnt_tick = 1'b0, irq_ack = 1'b0;
  logic [2:0]       port_val = '0;
  logic [2:0]       pin_out, pin_oe;
  logic             irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .irq_ack(irq_ack), .port_val(port_val),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 pin_oe reset", int'(pin_oe), 0);
    check("R1 irq reset", int'(irq), 0);
    check("R1 pin_out reset", int'(pin_out), 0);
    port_val = 3'b101;
    #1 check("R5 port value passes when code 0", int'(pin_out), 5);
  endtask

  task automatic t_regmap();
    int v;
    wr(3'd0, 16'h00A5); rd(3'd0, v); check("R2 control readback", v, 'hA5);
    wr(3'd6, 16'h0007); rd(3'd6, v); check("R2 direction readback", v, 7);
    wr(3'd3, 16'h1234); rd(3'd3, v); check("R2 compare B readback", v, 'h1234);
    check("R5 pin_oe follows direction", int'(pin_oe), 7);
    wr(3'd6, 16'h0002);
    #1 check("R5 pin_oe single bit", int'(pin_oe), 2);
    wr(3'd6, 16'h0007);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_toggle();
    int v;
    wr(3'd2, 16'd5); wr(3'd1, 16'd0); wr(3'd0, 16'h0040);
    ticks(6);
    rd(3'd1, v); check("R3 count after 6 advances", v, 6);
    check("R4 toggle A on match", int'(pin_out[0]), 1);
    wr(3'd1, 16'd5); ticks(1);
    check("R4 toggle A back", int'(pin_out[0]), 0);
  endtask

  task automatic t_setclr();
    wr(3'd3, 16'd3); wr(3'd4, 16'd3); wr(3'd1, 16'd0); wr(3'd0, 16'h003C);
    ticks(4);
    check("R4 set B and C, port A", int'(pin_out), 3'b111);
    wr(3'd0, 16'h0038); wr(3'd1, 16'd3); ticks(1);
    check("R4 clear C, B held high", int'(pin_out), 3'b011);
  endtask

  task automatic t_hold();
    wr(3'd0, 16'h0000);
    #1 check("R5 all pins on port value", int'(pin_out), 3'b101);
    wr(3'd1, 16'd3); ticks(1);
    wr(3'd0, 16'h0010);
    #1 check("R4 code 0 holds output through match", int'(pin_out[1]), 1);
    wr(3'd1, 16'd3); ticks(1);
    check("R4 toggle B after hold", int'(pin_out[1]), 0);
  endtask

  task automatic t_nomatch();
    wr(3'd1, 16'd9); wr(3'd3, 16'd9);
    repeat (3) @(negedge clk);
    check("R6 compare write alone no match", int'(pin_out[1]), 0);
    ticks(1);
    check("R6 advance makes match", int'(pin_out[1]), 1);
  endtask

  task automatic t_wrtick();
    int v;
    wr(3'd3, 16'hFFFF); wr(3'd1, 16'hFFFF);
    @(negedge clk);
    cnt_tick = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0020;
    @(negedge clk);
    cnt_tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    rd(3'd1, v); check("R7 write beats advance", v, 'h20);
    check("R7 no match on written cycle", int'(pin_out[1]), 1);
    check("R7 no overflow on written cycle", int'(irq), 0);
  endtask

  task automatic t_ctc();
    int v;
    wr(3'd0, 16'h0041); wr(3'd2, 16'd3); wr(3'd1, 16'd0);
    ticks(4);
    rd(3'd1, v); check("R8 restart to zero after A match", v, 0);
    check("R8 A toggles at restart", int'(pin_out[0]), 1);
    ticks(1);
    rd(3'd1, v); check("R8 counts on after restart", v, 1);
    wr(3'd0, 16'h0002); wr(3'd1, 16'd2); ticks(2);
    rd(3'd1, v); check("R3 reserved mode counts freely", v, 4);
    wr(3'd0, 16'h0001); wr(3'd2, 16'd9); wr(3'd1, 16'hFFFF); ticks(1);
    check("R8 no overflow flag in restart mode", int'(irq), 0);
  endtask

  task automatic t_ovf();
    int v;
    wr(3'd0, 16'h0000); wr(3'd1, 16'hFFFE); ticks(2);
    rd(3'd1, v); check("R3 wrap to zero", v, 0);
    rd(3'd5, v); check("R9 flag set on wrap", v, 1);
    check("R9 irq follows flag", int'(irq), 1);
    wr(3'd5, 16'h0000);
    check("R10 writing 0 keeps flag", int'(irq), 1);
    wr(3'd5, 16'h0001);
    check("R10 writing 1 clears flag", int'(irq), 0);
    wr(3'd1, 16'hFFFF); ticks(1);
    check("R9 flag set again", int'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 ack clears flag", int'(irq), 0);
  endtask

  task automatic t_race();
    wr(3'd1, 16'hFFFF);
    @(negedge clk); cnt_tick = 1'b1; irq_ack = 1'b1;
    @(negedge clk); cnt_tick = 1'b0; irq_ack = 1'b0;
    check("R11 set beats ack", int'(irq), 1);
    wr(3'd1, 16'hFFFF);
    @(negedge clk);
    cnt_tick = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0001;
    @(negedge clk);
    cnt_tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    check("R11 set beats write-one", int'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_toggle();
    t_setclr();
    t_hold();
    t_nomatch();
    t_wrtick();
    t_ctc();
    t_ovf();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule